// File: doc/BRIEF.md
# Framed and Unframed Serial Word Transmitter

This block sends fixed-width parallel words as a serial bit stream, most significant bit first, one bit for each pulse of a bit-rate enable (`bit_tick`) derived from the serial clock. A one-word holding buffer sits in front of the shift register. Software or a producer writes the next word while the current one is still leaving, and the following word then goes out with no gap.

Two control inputs configure each instance on its own. `cfg_framed` picks the framing mode. In framed mode, each word waits for its own frame sync on `fs_in`, and `fs_out` is driven active during that word's first bit. In unframed mode, one frame sync launches the stream. After that, words chain as long as the buffer is refilled in time, and `fs_in` has no effect while bits are moving. `cfg_fs_low` makes both frame-sync lines active low.

Sticky overflow and underflow flags report a dropped write and a broken stream. Each flag is cleared by pulsing its clear input. The engine has two states. TX_IDLE drives data low, and START moves it to TX_SHIFT when a frame sync coincides with a full buffer. In TX_SHIFT, NEXT_BIT moves to the following bit. At the word's last bit, CHAIN reloads from the buffer, and STOP returns to TX_IDLE.

Top module: `fsync_serial_tx`

## Requirements
- R1: After reset, `sd_out` is 0, `fs_out` is at its inactive level, `buf_empty` is 1, and both flags are 0.
- R2: `sd_out` changes only on a cycle where `bit_tick` is 1. A word of WORD_W bits is sent MSB first, one bit per tick, with the first bit visible in the cycle after the starting tick.
- R3: With `cfg_framed`=1, a word starts only on a tick where the frame sync is active and the buffer holds data. `fs_out` is active for exactly the tick period of that word's first bit. If an idle tick sees a frame sync but the buffer is empty, no word starts.
- R4: With `cfg_framed`=1, if the tick that follows a word's last bit sees an active frame sync and a full buffer, the next word starts with no gap. If that tick sees no frame sync, the engine returns to idle.
- R5: With `cfg_framed`=0, the first word needs a frame sync. Later words follow each other without one, and `fs_out` is active only for the first bit of the first word. `fs_in` is ignored while bits are being sent.
- R6: `cfg_fs_low`=0 makes `fs_in` and `fs_out` active high. `cfg_fs_low`=1 makes both active low.
- R7: `buf_empty` is 1 when the holding buffer has no word. A write while it is 1 is accepted, and the buffer empties when the engine loads the word.
- R8: A write while `buf_empty` is 0 is dropped, and `ovf_flag` is set in the next cycle.
- R9: `udf_flag` is set, and the engine goes idle with `sd_out` 0, in two cases. The first is an unframed word that ends with the buffer empty. The second is a framed word whose following tick sees an active frame sync with the buffer empty. After an unframed underflow, a new frame sync is needed to restart.
- R10: `clr_ovf` and `clr_udf` each clear their flag in the next cycle. A new event in the same cycle as the clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle enable per serial bit period |
| cfg_framed | input | 1 | 1 = frame sync per word, 0 = single sync then continuous |
| cfg_fs_low | input | 1 | 1 = frame-sync lines active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WORD_W | Word to transmit |
| buf_empty | output | 1 | Holding buffer has room |
| clr_ovf | input | 1 | Clear overflow flag (write one) |
| clr_udf | input | 1 | Clear underflow flag (write one) |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| udf_flag | output | 1 | Sticky: continuous stream was broken |
| fs_in | input | 1 | External frame sync |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame-sync marker on a word's first bit |

## Verification
The bench targets these cases:
- Frame-sync edges that toggle in the middle of an unframed stream. A design that re-armed on them would restart mid-word or raise `fs_out` again.
- Framed words presented with the sync held continuously, and framed words presented with the sync absent at the word boundary. Getting these wrong either inserts gaps or chains words that should have waited.
- An empty buffer at the last bit, in both modes. A design that handled this wrongly would keep shifting stale data, fail to flag underflow, or resume unframed output without a new sync.
- Writes into a full buffer, and clears that coincide with a new event, so a lost priority shows up as a flag dropping.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;

endpackage

// File: rtl/fstx_holdbuf.sv
module fstx_holdbuf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    input  logic              clr_ovf,
    output logic              full,
    output logic [WORD_W-1:0] data,
    output logic              ovf_flag
);

    logic drop_evt;
    assign drop_evt = wr_en & full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data     <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
            ovf_flag <= (ovf_flag & ~clr_ovf) | drop_evt;
        end
    end

    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf_flag);

    // R7
    take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

    // R7
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> full);

endmodule

// File: rtl/fstx_engine.sv
module fstx_engine
    import fstx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              framed,
    input  logic              fs_pol_low,
    input  logic              fs_in,
    input  logic              buf_full,
    input  logic [WORD_W-1:0] buf_data,
    input  logic              clr_udf,
    output logic              take,
    output logic              sd,
    output logic              mark,
    output logic              udf_flag
);

    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

    tx_state_e       state, state_nxt;
    logic [CW-1:0]   cnt;
    logic [WORD_W-1:0] sreg;
    logic            fs_act;
    logic            do_start, do_shift, do_stop, mark_new, udf_evt;

    assign fs_act = fs_in ^ fs_pol_low;
    assign take   = do_start;
    assign mark   = mark_q;

    logic mark_q;

    // next-state and transition decode
    always_comb begin
        state_nxt = state;
        do_start  = 1'b0;
        do_shift  = 1'b0;
        do_stop   = 1'b0;
        mark_new  = 1'b0;
        udf_evt   = 1'b0;
        if (tick) begin
            unique case (state)
                TX_IDLE: begin
                    if (fs_act && buf_full) begin          // START
                        do_start  = 1'b1;
                        mark_new  = 1'b1;
                        state_nxt = TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (cnt != '0) begin                   // NEXT_BIT
                        do_shift = 1'b1;
                    end else if (framed) begin
                        if (fs_act && buf_full) begin      // CHAIN (framed)
                            do_start = 1'b1;
                            mark_new = 1'b1;
                        end else begin                     // STOP
                            do_stop   = 1'b1;
                            udf_evt   = fs_act;
                            state_nxt = TX_IDLE;
                        end
                    end else if (buf_full) begin           // CHAIN (unframed)
                        do_start = 1'b1;
                    end else begin                         // STOP
                        do_stop   = 1'b1;
                        udf_evt   = 1'b1;
                        state_nxt = TX_IDLE;
                    end
                end
                default: state_nxt = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd       <= 1'b0;
            sreg     <= '0;
            cnt      <= '0;
            mark_q   <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (tick) begin
                mark_q <= mark_new;
                if (do_start) begin
                    sd   <= buf_data[WORD_W-1];
                    sreg <= buf_data << 1;
                    cnt  <= LAST_IDX;
                end else if (do_shift) begin
                    sd   <= sreg[WORD_W-1];
                    sreg <= sreg << 1;
                    cnt  <= cnt - 1'b1;
                end else if (do_stop) begin
                    sd <= 1'b0;
                end
            end
            udf_flag <= (udf_flag & ~clr_udf) | udf_evt;
        end
    end

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sd) && $stable(mark_q));

    // R5
    unframed_no_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed && tick && state == TX_SHIFT) |=> !mark_q);

    // R3
    framed_marks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (framed || state == TX_IDLE)) |=> mark_q);

    // R9
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> udf_flag);

    // R9
    idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SHIFT && state_nxt == TX_IDLE) |=> !sd);

endmodule

// File: rtl/fsync_serial_tx.sv
module fsync_serial_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              cfg_framed,
    input  logic              cfg_fs_low,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              buf_empty,
    input  logic              clr_ovf,
    input  logic              clr_udf,
    output logic              ovf_flag,
    output logic              udf_flag,
    input  logic              fs_in,
    output logic              sd_out,
    output logic              fs_out
);

    logic              buf_full;
    logic [WORD_W-1:0] buf_data;
    logic              take;
    logic              mark;

    fstx_holdbuf #(.WORD_W(WORD_W)) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .clr_ovf  (clr_ovf),
        .full     (buf_full),
        .data     (buf_data),
        .ovf_flag (ovf_flag)
    );

    fstx_engine #(.WORD_W(WORD_W)) i_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .framed     (cfg_framed),
        .fs_pol_low (cfg_fs_low),
        .fs_in      (fs_in),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .clr_udf    (clr_udf),
        .take       (take),
        .sd         (sd_out),
        .mark       (mark),
        .udf_flag   (udf_flag)
    );

    assign buf_empty = ~buf_full;
    assign fs_out    = mark ^ cfg_fs_low;

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !(wr_en && buf_full)) |=> !ovf_flag);

    // R10
    udf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_udf && !bit_tick) |=> !udf_flag);

endmodule

// File: tb/test_fsync_serial_tx.sv
module test_fsync_serial_tx;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_tick = 1'b0;
    logic         cfg_framed = 1'b1;
    logic         cfg_fs_low = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         clr_ovf = 1'b0;
    logic         clr_udf = 1'b0;
    logic         fs_in = 1'b0;
    logic         buf_empty, ovf_flag, udf_flag, sd_out, fs_out;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    fsync_serial_tx #(.WORD_W(W)) i_fsync_serial_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .cfg_framed(cfg_framed), .cfg_fs_low(cfg_fs_low),
        .wr_en(wr_en), .wr_data(wr_data), .buf_empty(buf_empty),
        .clr_ovf(clr_ovf), .clr_udf(clr_udf),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag),
        .fs_in(fs_in), .sd_out(sd_out), .fs_out(fs_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    // bit-rate enable: one cycle in four
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            k = (k + 1) % 4;
            bit_tick = (k == 0) && rst_n;
        end
    end

    // behavioural reference model
    logic [W-1:0] mq[$];
    logic [W-1:0] m_cur = '0;
    int           m_pos = 0;
    bit           m_act = 0, m_sd = 0, m_mark = 0, m_ovf = 0, m_udf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_act = 0; m_pos = 0; m_sd = 0; m_mark = 0; m_ovf = 0; m_udf = 0;
        end else begin
            bit had, fsa, ld, nm, uev, oev;
            had = (mq.size() > 0);
            fsa = fs_in ^ cfg_fs_low;
            ld = 0; nm = 0; uev = 0; oev = 0;
            if (bit_tick) begin
                m_mark = 0;
                if (!m_act) begin
                    if (fsa && had) begin ld = 1; nm = 1; end
                end else if (m_pos > 0) begin
                    m_pos = m_pos - 1;
                    m_sd  = m_cur[m_pos];
                end else if (cfg_framed) begin
                    if (fsa && had) begin ld = 1; nm = 1; end
                    else begin m_act = 0; m_sd = 0; uev = fsa; end
                end else if (had) begin
                    ld = 1;
                end else begin
                    m_act = 0; m_sd = 0; uev = 1;
                end
                if (ld) begin
                    m_cur = mq[0]; m_pos = W - 1; m_sd = m_cur[W-1];
                    m_act = 1; m_mark = nm;
                end
            end
            if (wr_en) begin
                if (had) oev = 1;
                else mq.push_back(wr_data);
            end
            if (ld) void'(mq.pop_front());
            m_ovf = (m_ovf && !clr_ovf) || oev;
            m_udf = (m_udf && !clr_udf) || uev;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%b expected=%b at %0t", tag, cur_req, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 sd_out", sd_out, m_sd);
            chk("R3 fs_out", fs_out, m_mark ? !cfg_fs_low : cfg_fs_low);
            chk("R7 buf_empty", buf_empty, mq.size() == 0);
            chk("R8 ovf_flag", ovf_flag, m_ovf);
            chk("R9 udf_flag", udf_flag, m_udf);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put(logic [W-1:0] w);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = w;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_fs(bit a);
        fs_in = a ^ cfg_fs_low;
    endtask

    task automatic wait_empty();
        @(posedge clk); #1;
        while (!buf_empty) begin @(posedge clk); #1; end
    endtask

    task automatic fs_pulse();
        set_fs(1); cyc(4); set_fs(0);
    endtask

    initial begin
        cyc(4);
        // R1 reset state
        @(negedge clk);
        chk("R1 sd_out", sd_out, 1'b0);
        chk("R1 fs_out", fs_out, 1'b0);
        chk("R1 buf_empty", buf_empty, 1'b1);
        chk("R1 ovf_flag", ovf_flag, 1'b0);
        chk("R1 udf_flag", udf_flag, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(6);

        // R3 framed single words; sync with empty buffer starts nothing
        cur_req = "R3";
        set_fs(1); cyc(8); set_fs(0);
        @(negedge clk); chk("R3 no start when empty", sd_out, 1'b0);
        put(16'hA5C3); cyc(6); fs_pulse();
        cyc(80);
        @(negedge clk); chk("R4 idle without sync", udf_flag, 1'b0);
        put(16'h8001); cyc(3); fs_pulse(); cyc(80);

        // R4 framed back-to-back with sync held
        cur_req = "R4";
        put(16'h1234); set_fs(1);
        wait_empty(); put(16'hFEDC);
        wait_empty(); put(16'h0F0F);
        wait_empty();
        // R9 framed underflow: sync active, buffer empty at boundary
        cur_req = "R9";
        cyc(90); set_fs(0);
        @(negedge clk); chk("R9 framed underflow", udf_flag, 1'b1);
        // R10 clear
        cur_req = "R10";
        @(posedge clk); #1; clr_udf = 1'b1; @(posedge clk); #1; clr_udf = 1'b0;
        @(negedge clk); chk("R10 udf cleared", udf_flag, 1'b0);

        // R5 unframed stream, fs toggling mid-stream is ignored
        cur_req = "R5";
        cfg_framed = 1'b0;
        put(16'hC0DE); fs_pulse();
        for (int i = 0; i < 4; i++) begin
            wait_empty();
            put(16'h1111 * (i + 3));
            cyc(9); set_fs(1); cyc(7); set_fs(0);
        end
        wait_empty();
        cur_req = "R9";
        cyc(90);
        @(negedge clk); chk("R9 unframed underflow", udf_flag, 1'b1);
        chk("R9 data low after underflow", sd_out, 1'b0);
        // R9 restart needs a new sync
        put(16'h5A5A); cyc(100);
        @(negedge clk); chk("R9 waits for sync", buf_empty, 1'b0);
        fs_pulse(); cyc(80);

        // R8 overflow, R10 clear colliding with new drop
        cur_req = "R8";
        cfg_framed = 1'b1;
        put(16'h7777); put(16'h9999);
        @(negedge clk); chk("R8 overflow set", ovf_flag, 1'b1);
        cur_req = "R10";
        @(posedge clk); #1;
        clr_ovf = 1'b1; wr_en = 1'b1; wr_data = 16'h2222;
        @(posedge clk); #1;
        clr_ovf = 1'b0; wr_en = 1'b0;
        @(negedge clk); chk("R10 set wins over clear", ovf_flag, 1'b1);
        @(posedge clk); #1; clr_ovf = 1'b1; @(posedge clk); #1; clr_ovf = 1'b0;
        @(negedge clk); chk("R10 ovf cleared", ovf_flag, 1'b0);
        fs_pulse(); cyc(80);

        // R6 active-low frame sync
        cur_req = "R6";
        @(posedge clk); #1;
        cfg_fs_low = 1'b1; set_fs(0);
        @(negedge clk); chk("R6 idle fs_out high", fs_out, 1'b1);
        put(16'hB00B); cyc(5);
        set_fs(1); cyc(8);
        set_fs(0);
        put(16'h4C4C); cyc(40); set_fs(1); cyc(4); set_fs(0);
        cyc(90);
        cfg_framed = 1'b0;
        put(16'h0001); fs_pulse(); wait_empty(); put(16'hFFFF); cyc(150);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_bad++;
        $display("FAIL watchdog [%s] actual=hung expected=finished", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule